// File: doc/BRIEF.md
# Command-Driven Seeded Random Generator

This block is a register-mapped random source. A small command set written to a control word tells it to do one of three things: nothing, fill its output words with fresh random data, or collect a new seed. It cannot produce output until it has been seeded. The seed comes from a single-bit entropy input qualified by a valid strobe. Each accepted sample is folded into a 64-bit shift state. Each generate step then advances that state by several bit positions and writes one 32-bit output word. A mode bit picks the request size: four words (128 bits) or eight words (256 bits).

Software sees the block through a simple 32-bit bus with one write port and one combinational read port. Completion shows up in a write-one-to-clear flag register, and a single interrupt line is gated by per-flag enables and a global enable. After reset the block seeds itself straight away. A programmable limit makes it reseed itself after a set number of completed generate requests.

The controller has four states. BOOT is the first seeding after reset. IDLE is seeded and waiting. RESEED is seeding again. GEN is filling words. The transitions are as follows:
- BOOT goes to IDLE (or to GEN if a request is pending) once the last sample arrives.
- IDLE goes to GEN on a generate command, or to RESEED on a seed command.
- GEN goes to RESEED when the auto-reseed limit is reached. Otherwise it goes to GEN again if a request is pending, or back to IDLE.
- RESEED leaves the same way BOOT does.

Top module: `seeded_rng`

## Requirements
- R1: Out of reset, the status word at 0x04 reads 0x8000_0000: reseeding (bit 31) is 1, seeded (bit 9) is 0 and generating (bit 30) is 0. The flag register at 0x14 reads 0, `irq` is 0, and the identification word at 0xF0 reads 0x0000_46BC.
- R2: Seeding completes on the clock edge that accepts the 64th entropy sample (`entropy_valid` high). From that edge on, status bit 9 is 1, bit 31 is 0, and flag bit 1 (seed done) is set. Once set, bit 9 never clears.
- R3: Writing 1 to the control word at 0x00 in IDLE raises status bit 30 from the write edge for N cycles. N is 4 when bit 3 of the size word at 0x08 is 0, and 8 when it is 1. On the N-th edge, bit 30 clears and flag bit 0 (data ready) sets. Bits 30 and 31 are never both set.
- R4: With size bit 3 = 0, a request rewrites output words 0 to 3 (0x20 to 0x2C) and leaves words 4 to 7 (0x30 to 0x3C) unchanged.
- R5: With size bit 3 = 1, a request rewrites all eight output words, 0x20 to 0x3C.
- R6: Writing the flag register at 0x14 clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: `irq` is 1 exactly when enable bit 31 at 0x10 is set and some flag bit is set with its enable set. Enable bit 1 gates seed done, and enable bit 0 gates data ready.
- R8: A generate command written before the block is seeded is held. The request starts on the edge that completes seeding, so status reads 0x4000_0200 right after that edge.
- R9: Writing 2 to the control word in IDLE makes the block collect 64 new samples. During this, status reads 0x8000_0200. Flag bit 1 sets when the new seed is complete.
- R10: When the limit word at 0x60 holds L, which must be nonzero, the L-th request completed since the last seeding sets data ready and enters reseeding on the same edge. Writing 0 to the limit word disables automatic reseeding.
- R11: Writing 0 (no operation) to the control word changes neither the status word nor the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Read data for rd_addr (combinational) |
| entropy_valid | input | 1 | Entropy sample strobe |
| entropy_bit | input | 1 | Entropy sample value |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational. A register write takes effect on the edge that samples it, and the bench reads at the falling edge after that edge. Status shows generating right after the write edge. Ready and the cleared busy bit appear after exactly 4 or 8 further edges, so the bench samples after N−1 edges and again after N edges to pin both sides of the transition. Seeding is checked one sample short of 64 and again after the 64th sample. The data-word checks compare against snapshots taken through the read port before the request, because the words' values come from entropy.

// File: rtl/rng_pkg.sv
package rng_pkg;

    typedef enum logic [1:0] {
        ST_BOOT,
        ST_IDLE,
        ST_RESEED,
        ST_GEN
    } rng_state_t;

    localparam logic [7:0] A_CMD  = 8'h00;
    localparam logic [7:0] A_STAT = 8'h04;
    localparam logic [7:0] A_SIZE = 8'h08;
    localparam logic [7:0] A_IEN  = 8'h10;
    localparam logic [7:0] A_IFLG = 8'h14;
    localparam logic [7:0] A_RLIM = 8'h60;
    localparam logic [7:0] A_ID   = 8'hF0;

    localparam logic [1:0] CMD_NOP  = 2'd0;
    localparam logic [1:0] CMD_RAND = 2'd1;
    localparam logic [1:0] CMD_SEED = 2'd2;

    localparam logic [31:0] ID_CODE = 32'h0000_46BC;

    localparam int B_SEEDED = 9;
    localparam int B_GEN    = 30;
    localparam int B_RESEED = 31;
    localparam int B_WIDE   = 3;
    localparam int B_GIE    = 31;

endpackage

// File: rtl/rng_mixer.sv
module rng_mixer #(
    parameter int STATE_W   = 64,
    parameter int WORD_W    = 32,
    parameter int STEP_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mix_en,
    input  logic              mix_bit,
    input  logic              step_en,
    output logic [WORD_W-1:0] word
);
    localparam logic [STATE_W-1:0] INIT_STATE = {{(STATE_W-8){1'b0}}, 8'hA5};

    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] adv;
    logic [STATE_W-1:0] state_d;

    always_comb begin
        adv = state_q;
        if (mix_en) begin
            adv = {adv[STATE_W-2:0],
                   adv[STATE_W-1] ^ adv[STATE_W-2] ^ adv[STATE_W-4] ^ adv[STATE_W-5] ^ mix_bit};
        end else if (step_en) begin
            for (int i = 0; i < STEP_BITS; i++) begin
                adv = {adv[STATE_W-2:0],
                       adv[STATE_W-1] ^ adv[STATE_W-2] ^ adv[STATE_W-4] ^ adv[STATE_W-5]};
            end
        end
        state_d = (adv == '0) ? INIT_STATE : adv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= INIT_STATE;
        else        state_q <= state_d;
    end

    assign word = state_d[WORD_W-1:0] ^ state_d[STATE_W-1:STATE_W-WORD_W];

endmodule

// File: rtl/rng_reseed_ctr.sv
module rng_reseed_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_done,
    input  logic             seed_done,
    input  logic [CNT_W-1:0] limit,
    output logic             reseed_due
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            count_q <= '0;
        else if (seed_done)                    count_q <= '0;
        else if (gen_done && count_q != '1)    count_q <= count_q + 1'b1;
    end

    assign reseed_due = (limit != '0) &&
                        ({1'b0, count_q} + 1'b1 >= {1'b0, limit});

endmodule

// File: rtl/rng_fsm.sv
module rng_fsm
    import rng_pkg::*;
#(
    parameter int SEED_SAMPLES = 64,
    parameter int NUM_WORDS    = 8,
    localparam int SMP_W = $clog2(SEED_SAMPLES),
    localparam int IDX_W = $clog2(NUM_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [1:0]       cmd_val,
    input  logic             wide_mode,
    input  logic             entropy_valid,
    input  logic             reseed_due,
    output logic             st_seeding,
    output logic             st_gen,
    output logic             seeded,
    output logic             seed_done,
    output logic             gen_done,
    output logic             mix_en,
    output logic             step_en,
    output logic [IDX_W-1:0] word_idx,
    output logic             gen_wide
);
    localparam logic [SMP_W-1:0] SMP_LAST    = SMP_W'(SEED_SAMPLES - 1);
    localparam logic [IDX_W-1:0] IDX_LAST_W  = IDX_W'(NUM_WORDS - 1);
    localparam logic [IDX_W-1:0] IDX_LAST_N  = IDX_W'(NUM_WORDS / 2 - 1);

    rng_state_t       state_q, state_d;
    logic [SMP_W-1:0] smp_q;
    logic [IDX_W-1:0] idx_q;
    logic             pend_q;
    logic             wide_q;
    logic             rand_cmd, seed_cmd, last_smp, last_word, start_gen;

    assign rand_cmd  = cmd_wr && (cmd_val == CMD_RAND);
    assign seed_cmd  = cmd_wr && (cmd_val == CMD_SEED);
    assign last_smp  = entropy_valid && (smp_q == SMP_LAST);
    assign last_word = (idx_q == (wide_q ? IDX_LAST_W : IDX_LAST_N));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT, ST_RESEED: begin
                if (last_smp) state_d = (pend_q || rand_cmd) ? ST_GEN : ST_IDLE;
            end
            ST_IDLE: begin
                if (rand_cmd || pend_q) state_d = ST_GEN;
                else if (seed_cmd)      state_d = ST_RESEED;
            end
            ST_GEN: begin
                if (last_word) begin
                    if (reseed_due)               state_d = ST_RESEED;
                    else if (pend_q || rand_cmd)  state_d = ST_GEN;
                    else                          state_d = ST_IDLE;
                end
            end
            default: state_d = ST_BOOT;
        endcase
    end

    assign start_gen = (state_d == ST_GEN) && ((state_q != ST_GEN) || last_word);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q  <= '0;
            idx_q  <= '0;
            pend_q <= 1'b0;
            wide_q <= 1'b0;
        end else begin
            if (st_seeding && entropy_valid)
                smp_q <= last_smp ? '0 : smp_q + 1'b1;
            if (state_q == ST_GEN)
                idx_q <= last_word ? '0 : idx_q + 1'b1;
            if (start_gen) begin
                pend_q <= 1'b0;
                wide_q <= wide_mode;
            end else if (rand_cmd && state_q != ST_IDLE) begin
                pend_q <= 1'b1;
            end
        end
    end

    always_comb begin
        st_seeding = 1'b0;
        st_gen     = 1'b0;
        seed_done  = 1'b0;
        gen_done   = 1'b0;
        mix_en     = 1'b0;
        step_en    = 1'b0;
        unique case (state_q)
            ST_BOOT, ST_RESEED: begin
                st_seeding = 1'b1;
                mix_en     = entropy_valid;
                seed_done  = last_smp;
            end
            ST_GEN: begin
                st_gen   = 1'b1;
                step_en  = 1'b1;
                gen_done = last_word;
            end
            default: ;
        endcase
    end

    assign seeded   = (state_q != ST_BOOT);
    assign word_idx = idx_q;
    assign gen_wide = wide_q;

endmodule

// File: rtl/seeded_rng.sv
module seeded_rng
    import rng_pkg::*;
#(
    parameter int SEED_SAMPLES = 64,
    parameter int CNT_W        = 16,
    parameter int STATE_W      = 64,
    parameter int STEP_BITS    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [7:0]  rd_addr,
    output logic [31:0] rd_data,
    input  logic        entropy_valid,
    input  logic        entropy_bit,
    output logic        irq
);
    localparam int NUM_WORDS = 8;
    localparam int WORD_W    = 32;
    localparam int IDX_W     = $clog2(NUM_WORDS);

    logic             st_seeding, st_gen, seeded, seed_done, gen_done;
    logic             mix_en, step_en, gen_wide, reseed_due;
    logic [IDX_W-1:0] word_idx;
    logic [WORD_W-1:0] mix_word;
    logic [WORD_W-1:0] out_words [NUM_WORDS];

    logic             wide_q;
    logic             gie_q, seed_ie_q, rdy_ie_q;
    logic [1:0]       flags_q;
    logic [CNT_W-1:0] limit_q;

    logic cmd_wr;
    assign cmd_wr = wr_en && (wr_addr == A_CMD);

    rng_fsm #(.SEED_SAMPLES(SEED_SAMPLES), .NUM_WORDS(NUM_WORDS)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(cmd_wr), .cmd_val(wr_data[1:0]), .wide_mode(wide_q),
        .entropy_valid(entropy_valid), .reseed_due(reseed_due),
        .st_seeding(st_seeding), .st_gen(st_gen), .seeded(seeded),
        .seed_done(seed_done), .gen_done(gen_done),
        .mix_en(mix_en), .step_en(step_en),
        .word_idx(word_idx), .gen_wide(gen_wide)
    );

    rng_mixer #(.STATE_W(STATE_W), .WORD_W(WORD_W), .STEP_BITS(STEP_BITS)) u_mix (
        .clk(clk), .rst_n(rst_n),
        .mix_en(mix_en), .mix_bit(entropy_bit), .step_en(step_en),
        .word(mix_word)
    );

    rng_reseed_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n),
        .gen_done(gen_done), .seed_done(seed_done),
        .limit(limit_q), .reseed_due(reseed_due)
    );

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                out_words[i] <= '0;
            else if (step_en && word_idx == IDX_W'(i))
                out_words[i] <= mix_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wide_q    <= 1'b0;
            gie_q     <= 1'b0;
            seed_ie_q <= 1'b0;
            rdy_ie_q  <= 1'b0;
            limit_q   <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_SIZE) wide_q <= wr_data[B_WIDE];
            if (wr_addr == A_IEN) begin
                gie_q     <= wr_data[B_GIE];
                seed_ie_q <= wr_data[1];
                rdy_ie_q  <= wr_data[0];
            end
            if (wr_addr == A_RLIM) limit_q <= wr_data[CNT_W-1:0];
        end
    end

    logic [1:0] clr_mask;
    assign clr_mask = (wr_en && wr_addr == A_IFLG) ? wr_data[1:0] : 2'b00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= 2'b00;
        else        flags_q <= {seed_done, gen_done} | (flags_q & ~clr_mask);
    end

    assign irq = gie_q && ((seed_ie_q && flags_q[1]) || (rdy_ie_q && flags_q[0]));

    always_comb begin
        rd_data = '0;
        if (rd_addr[7:5] == 3'b001 && rd_addr[1:0] == 2'b00) begin
            rd_data = out_words[rd_addr[4:2]];
        end else begin
            case (rd_addr)
                A_STAT: begin
                    rd_data[B_RESEED] = st_seeding;
                    rd_data[B_GEN]    = st_gen;
                    rd_data[B_SEEDED] = seeded;
                end
                A_SIZE: rd_data[B_WIDE] = wide_q;
                A_IEN:  rd_data = {gie_q, 29'd0, seed_ie_q, rdy_ie_q};
                A_IFLG: rd_data = {30'd0, flags_q};
                A_RLIM: rd_data = {{(32-CNT_W){1'b0}}, limit_q};
                A_ID:   rd_data = ID_CODE;
                default: rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/seeded_rng_chk.sv
module seeded_rng_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        st_gen,
    input logic        st_seeding,
    input logic        seeded,
    input logic [1:0]  flags,
    input logic        gie,
    input logic        seed_ie,
    input logic        rdy_ie,
    input logic        irq,
    input logic        gen_wide,
    input logic [31:0] w_hi
);
    // R3
    busy_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_gen && st_seeding));

    // R3
    ready_after_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> $past(st_gen));

    // R2
    seeded_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seeded |=> seeded);

    // R7
    irq_needs_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> gie);

    // R7
    irq_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((seed_ie && flags[1]) || (rdy_ie && flags[0])));

    // R4
    narrow_upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_gen && !gen_wide) |=> $stable(w_hi));

endmodule

bind seeded_rng seeded_rng_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .st_gen(st_gen), .st_seeding(st_seeding), .seeded(seeded),
    .flags(flags_q), .gie(gie_q), .seed_ie(seed_ie_q), .rdy_ie(rdy_ie_q),
    .irq(irq), .gen_wide(gen_wide), .w_hi(out_words[4])
);

// File: tb/seeded_rng_tb_top.sv
`timescale 1ns/1ps
module seeded_rng_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        entropy_valid = 1'b0;
    logic        entropy_bit = 1'b0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int pushed = 0;
    int consumed = 0;
    int ent_cnt = 0;
    bit done = 0;

    typedef struct {
        int          addr;   // -1 selects the irq pin
        int          kind;   // 0 equal, 1 snapshot, 2 differs from snapshot, 3 equals snapshot
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       exp_q[$];
    logic [31:0] snap [8];

    always #2 clk = ~clk;

    seeded_rng dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .entropy_valid(entropy_valid), .entropy_bit(entropy_bit),
        .irq(irq)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            item_t it;
            logic [31:0] act;
            int si;
            wait (exp_q.size() != 0);
            it = exp_q.pop_front();
            if (it.addr >= 0) rd_addr = it.addr[7:0];
            #0.01;
            act = (it.addr < 0) ? {31'd0, irq} : rd_data;
            si  = (it.addr - 'h20) / 4;
            case (it.kind)
                0: begin
                    checks++;
                    if (act !== it.exp) begin
                        errors++;
                        $display("FAIL %s addr=%0h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
                    end
                end
                1: snap[si] = act;
                2: begin
                    checks++;
                    if (act === snap[si]) begin
                        errors++;
                        $display("FAIL %s addr=%0h actual=%h expected a value other than %h", it.tag, it.addr, act, snap[si]);
                    end
                end
                default: begin
                    checks++;
                    if (act !== snap[si]) begin
                        errors++;
                        $display("FAIL %s addr=%0h actual=%h expected=%h", it.tag, it.addr, act, snap[si]);
                    end
                end
            endcase
            consumed++;
        end
    end

    task automatic push(input int addr, input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.addr = addr; it.kind = kind; it.exp = exp; it.tag = tag;
        exp_q.push_back(it);
        pushed++;
        wait (consumed == pushed);
    endtask

    task automatic expect_reg(input int addr, input logic [31:0] exp, input string tag);
        push(addr, 0, exp, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic feed(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            entropy_valid = 1'b1;
            entropy_bit   = ent_cnt[0] ^ ent_cnt[3] ^ ent_cnt[5];
            ent_cnt++;
        end
        @(negedge clk);
        entropy_valid = 1'b0;
    endtask

    task automatic snap_all();
        for (int i = 0; i < 8; i++) push('h20 + 4 * i, 1, '0, "snap");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_reg('h04, 32'h8000_0000, "R1 status");
        expect_reg('h14, 32'h0, "R1 flags");
        expect_reg('hF0, 32'h0000_46BC, "R1 id");
        expect_reg(-1, 32'h0, "R1 irq");

        // R8 request held until boot seeding completes
        wr(8'h00, 32'd1);
        expect_reg('h04, 32'h8000_0000, "R8 held");
        feed(63);
        expect_reg('h04, 32'h8000_0000, "R2 one sample short");
        feed(1);
        expect_reg('h04, 32'h4000_0200, "R8 gen starts on seed edge");
        expect_reg('h14, 32'h2, "R2 seed done flag");
        repeat (3) @(negedge clk);
        expect_reg('h04, 32'h4000_0200, "R3 still generating");
        @(negedge clk);
        expect_reg('h04, 32'h0000_0200, "R3 idle after 4");
        expect_reg('h14, 32'h3, "R3 ready flag");

        // R6 write-one-to-clear
        wr(8'h14, 32'h1);
        expect_reg('h14, 32'h2, "R6 clear bit0");
        wr(8'h14, 32'h0);
        expect_reg('h14, 32'h2, "R6 zero write keeps");
        wr(8'h14, 32'h2);
        expect_reg('h14, 32'h0, "R6 clear bit1");

        // R11 no-op command
        wr(8'h00, 32'd0);
        expect_reg('h04, 32'h0000_0200, "R11 status unchanged");
        expect_reg('h14, 32'h0, "R11 flags unchanged");

        // R4 narrow request
        snap_all();
        wr(8'h00, 32'd1);
        repeat (3) @(negedge clk);
        expect_reg('h14, 32'h0, "R3 not ready at 3");
        @(negedge clk);
        expect_reg('h14, 32'h1, "R3 ready at 4");
        for (int i = 0; i < 4; i++) push('h20 + 4 * i, 2, '0, "R4 low word rewritten");
        for (int i = 4; i < 8; i++) push('h20 + 4 * i, 3, '0, "R4 high word kept");

        // R7 interrupt gating
        wr(8'h10, 32'h0000_0001);
        expect_reg(-1, 32'h0, "R7 no global");
        wr(8'h10, 32'h8000_0002);
        expect_reg(-1, 32'h0, "R7 source disabled");
        wr(8'h10, 32'h8000_0001);
        expect_reg(-1, 32'h1, "R7 ready irq");
        wr(8'h14, 32'h1);
        expect_reg(-1, 32'h0, "R7 irq drops on clear");

        // R5 wide request
        wr(8'h08, 32'h8);
        snap_all();
        wr(8'h00, 32'd1);
        repeat (7) @(negedge clk);
        expect_reg('h04, 32'h4000_0200, "R3 wide still generating");
        @(negedge clk);
        expect_reg('h04, 32'h0000_0200, "R3 wide idle after 8");
        expect_reg(-1, 32'h1, "R7 irq on ready");
        for (int i = 0; i < 8; i++) push('h20 + 4 * i, 2, '0, "R5 word rewritten");
        wr(8'h14, 32'h3);

        // R9 seed command
        wr(8'h10, 32'h8000_0002);
        wr(8'h00, 32'd2);
        expect_reg('h04, 32'h8000_0200, "R9 reseeding");
        feed(64);
        expect_reg('h04, 32'h0000_0200, "R9 idle after seed");
        expect_reg('h14, 32'h2, "R9 seed done flag");
        expect_reg(-1, 32'h1, "R7 seed irq");
        wr(8'h14, 32'h3);

        // R10 auto reseed after two requests
        wr(8'h08, 32'h0);
        wr(8'h60, 32'd2);
        wr(8'h00, 32'd1);
        repeat (4) @(negedge clk);
        expect_reg('h04, 32'h0000_0200, "R10 first request no reseed");
        wr(8'h14, 32'h1);
        wr(8'h00, 32'd1);
        repeat (4) @(negedge clk);
        expect_reg('h04, 32'h8000_0200, "R10 reseed after limit");
        expect_reg('h14, 32'h1, "R10 ready with reseed");
        feed(64);
        expect_reg('h04, 32'h0000_0200, "R10 idle after auto seed");
        expect_reg('h14, 32'h3, "R10 seed done");

        // R10 limit zero disables
        wr(8'h60, 32'd0);
        wr(8'h14, 32'h3);
        for (int k = 0; k < 3; k++) begin
            wr(8'h00, 32'd1);
            repeat (4) @(negedge clk);
        end
        expect_reg('h04, 32'h0000_0200, "R10 disabled stays idle");

        finish_run();
    end

endmodule